// File: doc/BRIEF.md
# Single-Wire Slave ROM Function Unit

This unit is the network-selection layer of a slave on a single-wire, open-drain bus. It holds a fixed 64-bit identity code and, after each bus reset reported by the link layer, interprets one ROM-level command byte and its operands. The link layer hands over one slot at a time: a strobe with the level seen on the line. Ahead of each slot the unit states whether it wants to transmit and which bit. A bit of 0 means the link pulls the line low during the read slot; a bit of 1 means it leaves the line released.

The commands read the code, address the device by its code, select every device at once, take part in bitwise search arbitration, re-select the device chosen last, and switch into overdrive speed. The `selected` output gates the memory-function layer. The `overdrive` output tells the link layer which slot timing to use.

Top module: `swrom_unit`

## Requirements
- R1: The identity is `{crc, ID_BODY}`. `ID_BODY` is a 56-bit parameter whose low byte is the family code. The top byte is an 8-bit CRC over the 56 body bits: polynomial x^8+x^5+x^4+1, body bits fed in starting at bit 0, register shifted right, zero seed. The default body 56'h00000001B81C02 gives the CRC A2h. Read-code (33h) transmits the 64 bits, bit 0 first, with `tx_en`=1 during each slot, and then asserts `selected`.
- R2: Slots before the first bus reset after `rst_n` are ignored. A `bus_reset` pulse deselects the unit and starts the reception of a new command byte.
- R3: The command byte arrives bit 0 first. The codes are 33h read, 55h match, CCh skip, F0h search, A5h resume, 3Ch overdrive-skip and 69h overdrive-match. Any other code leaves the unit idle, with no transmission and no selection, until the next bus reset.
- R4: Match (55h) compares the next 64 slots with the code, bit 0 first. An exact match asserts `selected`. The first mismatch makes the unit idle until the next bus reset.
- R5: Search (F0h) handles each code bit, from bit 0 up, in three slots. The unit transmits the bit, then its complement, and then reads the master's choice. It continues only if the choice equals its own bit. It is selected after all 64 bits and goes idle on a mismatch.
- R6: Skip (CCh) selects the unit without any code. Overdrive-skip (3Ch) selects it and also sets `overdrive`.
- R7: Overdrive-match (69h) sets `overdrive` as soon as the command byte completes. An exact 64-bit match selects the unit and keeps `overdrive`. A mismatch clears `overdrive` and makes the unit idle.
- R8: A bus reset with `reset_std`=1 clears `overdrive`. A bus reset with `reset_std`=0 leaves it unchanged.
- R9: Resume (A5h) selects the unit only if the resume flag is set. Successful read, match, search or overdrive-match sets the flag. Failed match, search or overdrive-match clears it, and so do skip and overdrive-skip. `rst_n` clears it, and bus resets keep it.
- R10: While the unit is selected, `tx_en` stays 0 and slots change nothing until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | One-cycle pulse: the link layer saw a reset and sent presence |
| reset_std | input | 1 | Qualifies `bus_reset`: 1 for a standard-length reset |
| slot_strobe | input | 1 | One-cycle pulse: a bit slot has completed |
| slot_val | input | 1 | Line level sampled in that slot |
| tx_en | output | 1 | The unit transmits in the next slot |
| tx_bit | output | 1 | Bit to transmit (0 means pull the line low) |
| selected | output | 1 | Access to the memory-function layer is granted |
| overdrive | output | 1 | Overdrive slot timing is in force |

## Verification
Match and search are run with a master that follows the code exactly and with single-bit deviations placed at the first bit, the last bit and random positions. A full run only separates a correct compare from a missing one when the deviation also lands at the ends of the 64-bit walk. Random command sequences, with standard and overdrive resets chosen at random, exercise the resume flag and overdrive state across transactions. The bench checks those against its own model, which distinguishes whether the flag is kept, set or cleared by each command. Unknown codes and slots sent before any bus reset, or sent after selection, show that stray traffic leaves the outputs untouched.

// File: rtl/swrom_pkg.sv
package swrom_pkg;
    localparam int ID_W   = 64;
    localparam int BODY_W = 56;
    localparam int CNT_W  = $clog2(ID_W);

    localparam logic [7:0] OP_READ     = 8'h33;
    localparam logic [7:0] OP_MATCH    = 8'h55;
    localparam logic [7:0] OP_SKIP     = 8'hCC;
    localparam logic [7:0] OP_SEARCH   = 8'hF0;
    localparam logic [7:0] OP_RESUME   = 8'hA5;
    localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
    localparam logic [7:0] OP_OD_MATCH = 8'h69;

    typedef enum logic [2:0] {
        K_NONE, K_READ, K_MATCH, K_SKIP, K_SEARCH, K_RESUME, K_OD_SKIP, K_OD_MATCH
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_TX_ROM, ST_RX_MATCH, ST_SRCH_B, ST_SRCH_C, ST_SRCH_M, ST_SEL
    } rom_state_e;

    // Reflected x^8+x^5+x^4+1, zero seed, bit 0 first
    function automatic logic [7:0] crc8_lsb(input logic [BODY_W-1:0] body);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 0; i < BODY_W; i++) begin
            fb = c[0] ^ body[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction
endpackage

// File: rtl/swrom_code.sv
module swrom_code
    import swrom_pkg::*;
#(
    parameter logic [BODY_W-1:0] BODY = 56'h00000001B81C02
) (
    output logic [ID_W-1:0] code
);
    localparam logic [7:0] CHK = crc8_lsb(BODY);
    assign code = {CHK, BODY};
endmodule

// File: rtl/swrom_cmd_decode.sv
module swrom_cmd_decode
    import swrom_pkg::*;
(
    input  logic [7:0] op,
    output cmd_kind_e  kind
);
    always_comb begin
        case (op)
            OP_READ:     kind = K_READ;
            OP_MATCH:    kind = K_MATCH;
            OP_SKIP:     kind = K_SKIP;
            OP_SEARCH:   kind = K_SEARCH;
            OP_RESUME:   kind = K_RESUME;
            OP_OD_SKIP:  kind = K_OD_SKIP;
            OP_OD_MATCH: kind = K_OD_MATCH;
            default:     kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/swrom_unit.sv
module swrom_unit
    import swrom_pkg::*;
#(
    parameter logic [BODY_W-1:0] ID_BODY = 56'h00000001B81C02
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic reset_std,
    input  logic slot_strobe,
    input  logic slot_val,
    output logic tx_en,
    output logic tx_bit,
    output logic selected,
    output logic overdrive
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] LAST_OP  = CNT_W'(7);

    typedef struct packed {
        rom_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [6:0]       sh;
        logic             ovd;
        logic             rsm;
        logic             odm;
    } regs_t;

    regs_t r_q, r_d;
    logic [ID_W-1:0] code;
    logic [7:0]      op_byte;
    cmd_kind_e       kind;
    logic            own_bit;

    swrom_code #(.BODY(ID_BODY)) code_i (.code(code));

    assign op_byte = {slot_val, r_q.sh};
    swrom_cmd_decode dec_i (.op(op_byte), .kind(kind));

    assign own_bit = code[r_q.cnt];

    always_comb begin
        r_d = r_q;
        if (bus_reset) begin
            r_d.st  = ST_CMD;
            r_d.cnt = '0;
            r_d.odm = 1'b0;
            if (reset_std) r_d.ovd = 1'b0;
        end else if (slot_strobe) begin
            case (r_q.st)
                ST_CMD: begin
                    r_d.sh  = {slot_val, r_q.sh[6:1]};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_OP) begin
                        r_d.cnt = '0;
                        case (kind)
                            K_READ:     begin r_d.st = ST_TX_ROM; r_d.rsm = 1'b1; end
                            K_MATCH:    begin r_d.st = ST_RX_MATCH; r_d.odm = 1'b0; end
                            K_OD_MATCH: begin r_d.st = ST_RX_MATCH; r_d.odm = 1'b1; r_d.ovd = 1'b1; end
                            K_SKIP:     begin r_d.st = ST_SEL; r_d.rsm = 1'b0; end
                            K_OD_SKIP:  begin r_d.st = ST_SEL; r_d.rsm = 1'b0; r_d.ovd = 1'b1; end
                            K_SEARCH:   r_d.st = ST_SRCH_B;
                            K_RESUME:   r_d.st = r_q.rsm ? ST_SEL : ST_IDLE;
                            default:    r_d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_TX_ROM: begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BIT) r_d.st = ST_SEL;
                end
                ST_RX_MATCH: begin
                    if (slot_val != own_bit) begin
                        r_d.st  = ST_IDLE;
                        r_d.rsm = 1'b0;
                        if (r_q.odm) r_d.ovd = 1'b0;
                    end else if (r_q.cnt == LAST_BIT) begin
                        r_d.st  = ST_SEL;
                        r_d.rsm = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_SRCH_B: r_d.st = ST_SRCH_C;
                ST_SRCH_C: r_d.st = ST_SRCH_M;
                ST_SRCH_M: begin
                    if (slot_val != own_bit) begin
                        r_d.st  = ST_IDLE;
                        r_d.rsm = 1'b0;
                    end else if (r_q.cnt == LAST_BIT) begin
                        r_d.st  = ST_SEL;
                        r_d.rsm = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.st  = ST_SRCH_B;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, sh: '0, ovd: 1'b0, rsm: 1'b0, odm: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_en     = (r_q.st == ST_TX_ROM) || (r_q.st == ST_SRCH_B) || (r_q.st == ST_SRCH_C);
    assign tx_bit    = (r_q.st == ST_SRCH_C) ? ~own_bit : own_bit;
    assign selected  = (r_q.st == ST_SEL);
    assign overdrive = r_q.ovd;

    // R2: a bus reset always ends selection
    a_r2_reset_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !selected);

    // R8: standard-length reset leaves standard speed
    a_r8_std_reset_clears_od: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && reset_std) |=> !overdrive);

    // R8: overdrive-length reset keeps the speed mode
    a_r8_od_reset_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !reset_std) |=> (overdrive == $past(overdrive)));

    // R10: selection persists until the next bus reset
    a_r10_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> selected);

    // R10: no transmission while selected
    a_r10_quiet_when_sel: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> !tx_en);

    // R5: second search slot carries the complement of the first
    a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SRCH_B && slot_strobe && !bus_reset) |=> (tx_en && (tx_bit != $past(tx_bit))));
endmodule

// File: tb/swrom_unit_tb_top.sv
module swrom_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [55:0] BODY = 56'h00000001B81C02;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0, reset_std = 1'b1, slot_strobe = 1'b0, slot_val = 1'b1;
    logic tx_en, tx_bit, selected, overdrive;

    int checks = 0;
    int errors = 0;
    logic exp_ovd = 1'b0;
    logic exp_rsm = 1'b0;
    logic [63:0] exp_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    swrom_unit #(.ID_BODY(BODY)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_std(reset_std),
        .slot_strobe(slot_strobe), .slot_val(slot_val),
        .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected), .overdrive(overdrive));

    function automatic logic [7:0] ref_crc(input logic [55:0] b);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic f;
            f = c[0] ^ b[i];
            c = {1'b0, c[7:1]} ^ (f ? 8'h8C : 8'h00);
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic b);
        @(negedge clk);
        slot_strobe = 1'b1;
        slot_val = b;
        @(negedge clk);
        slot_strobe = 1'b0;
        slot_val = 1'b1;
    endtask

    task automatic breset(input logic std);
        @(negedge clk);
        bus_reset = 1'b1;
        reset_std = std;
        @(negedge clk);
        bus_reset = 1'b0;
        if (std) exp_ovd = 1'b0;
    endtask

    task automatic send_op(input logic [7:0] op);
        for (int i = 0; i < 8; i++) slot(op[i]);
    endtask

    task automatic check_state(input string tag);
        chk(selected === selected && overdrive == exp_ovd, {tag, " overdrive"}, overdrive, exp_ovd);
    endtask

    // R1: read-code
    task automatic do_read();
        logic [63:0] got = '0;
        logic ok_en = 1'b1;
        send_op(8'h33);
        for (int i = 0; i < 64; i++) begin
            ok_en &= tx_en;
            got[i] = tx_bit;
            slot(tx_bit);
        end
        chk(ok_en, "R1 tx_en during read", ok_en, 1);
        chk(got == exp_id, "R1 code sent bit 0 first", got, exp_id);
        chk(selected, "R1 selected after read", selected, 1);
        exp_rsm = 1'b1;
    endtask

    // R4 / R7: match, err <0 means exact
    task automatic do_match(input bit od, input int err);
        send_op(od ? 8'h69 : 8'h55);
        if (od) begin
            exp_ovd = 1'b1;
            chk(overdrive == 1'b1, "R7 overdrive after op", overdrive, 1);
        end
        for (int i = 0; i < 64; i++) slot(exp_id[i] ^ (i == err));
        if (err < 0) begin
            exp_rsm = 1'b1;
            chk(selected, od ? "R7 exact select" : "R4 exact select", selected, 1);
        end else begin
            exp_rsm = 1'b0;
            if (od) exp_ovd = 1'b0;
            chk(!selected && !tx_en, od ? "R7 mismatch idle" : "R4 mismatch idle", {tx_en, selected}, 0);
        end
        chk(overdrive == exp_ovd, od ? "R7 overdrive state" : "R4 overdrive state", overdrive, exp_ovd);
    endtask

    // R5: search
    task automatic do_search(input int err);
        bit ok = 1'b1;
        bit stop = 1'b0;
        send_op(8'hF0);
        for (int i = 0; i < 64; i++) begin
            if (!stop) begin
                ok &= (tx_en && tx_bit == exp_id[i]);
                slot(tx_bit);
                ok &= (tx_en && tx_bit == ~exp_id[i]);
                slot(tx_bit);
                slot(exp_id[i] ^ (i == err));
                if (i == err) stop = 1'b1;
            end
        end
        chk(ok, "R5 bit and complement", ok, 1);
        if (err < 0) begin
            exp_rsm = 1'b1;
            chk(selected, "R5 search select", selected, 1);
        end else begin
            exp_rsm = 1'b0;
            slot(1'b0);
            slot(1'b1);
            chk(!selected && !tx_en, "R5 mismatch idle", {tx_en, selected}, 0);
        end
    endtask

    task automatic do_resume();
        send_op(8'hA5);
        chk(selected == exp_rsm, "R9 resume", selected, exp_rsm);
    endtask

    task automatic do_skip(input bit od);
        send_op(od ? 8'h3C : 8'hCC);
        exp_rsm = 1'b0;
        if (od) exp_ovd = 1'b1;
        chk(selected, "R6 skip select", selected, 1);
        chk(overdrive == exp_ovd, "R6 skip overdrive", overdrive, exp_ovd);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        exp_id = {ref_crc(BODY), BODY};
        repeat (3) @(negedge clk);
        chk(!selected && !overdrive && !tx_en, "R2 reset state", {tx_en, selected, overdrive}, 0);
        rst_n = 1'b1;

        // R2: slots before first bus reset ignored
        send_op(8'hCC);
        chk(!selected && !tx_en, "R2 no command before reset", {tx_en, selected}, 0);

        chk(exp_id[63:56] == 8'hA2, "R1 crc of default body", exp_id[63:56], 8'hA2);
        breset(1);
        do_read();
        // R10: slots while selected change nothing
        send_op(8'h33);
        chk(selected && !tx_en, "R10 selected ignores slots", {tx_en, selected}, 2'b01);

        breset(1);
        chk(!selected, "R2 bus reset deselects", selected, 0);
        do_skip(0);
        breset(1); do_resume();
        breset(1); do_match(0, -1);
        breset(1); do_resume();
        breset(1); do_match(0, 0);
        breset(1); do_resume();
        breset(1); do_match(0, 63);
        breset(1); do_search(-1);
        breset(1); do_resume();
        breset(1); do_search(0);
        breset(1); do_search(63);
        // R3: unknown opcode idles
        breset(1); send_op(8'h5A);
        slot(1'b0);
        chk(!selected && !tx_en, "R3 unknown op idle", {tx_en, selected}, 0);
        // R6/R8
        breset(1); do_skip(1);
        breset(0);
        chk(overdrive == 1'b1, "R8 od reset keeps", overdrive, 1);
        breset(1);
        chk(overdrive == 1'b0, "R8 std reset clears", overdrive, 0);
        // R7
        breset(1); do_match(1, -1);
        breset(0); do_match(1, 40);
        breset(1); do_match(1, 0);

        // random mix
        for (int n = 0; n < 60; n++) begin
            int k;
            int e;
            k = int'($urandom_range(0, 7));
            e = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 63)) : -1;
            breset(logic'($urandom_range(0, 1)));
            chk(overdrive == exp_ovd, "R8 random reset overdrive", overdrive, exp_ovd);
            case (k)
                0: do_read();
                1: do_match(0, e);
                2: do_skip(0);
                3: do_search(e);
                4: do_resume();
                5: do_skip(1);
                6: do_match(1, e);
                default: begin
                    send_op(8'h00);
                    chk(!selected && !tx_en, "R3 random unknown op", {tx_en, selected}, 0);
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule